// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog peripheral with a word-wide register bus. A down-counter advances one step on each cycle in which the timer enable input is high and counting is enabled. When the counter passes zero, the block raises a level interrupt and starts a fresh period from the programmed load value. Software services the watchdog by clearing the interrupt, rewriting the load value, or both; either action restarts the period at once.

If software fails to clear the interrupt before the counter runs out again, the block drives a system reset request. That request stays high until the watchdog's own reset is applied. With a load value of L, the interrupt comes L+1 enabled ticks after a restart, and the reset follows a further L+1 ticks. The worst-case time to reset is therefore about twice the programmed period.

The load, control and interrupt-clear registers are guarded by a write lock. Writing the 32-bit key `32'h1ACCE551` to the lock register opens them. Writing any other value there closes them again. The lock register can be read back, so software can confirm the state after its write sequence.

Top module: `wdog_two_stage`

## Requirements
- R1: A write to the lock register (word index 3) of `32'h1ACCE551` unlocks the block, and a write of any other value locks it. Reading the lock register returns 1 when locked and 0 when unlocked. After reset the block is unlocked.
- R2: While the block is locked, writes to the load, control and interrupt-clear registers have no effect on any register, on the counter or on the outputs.
- R3: After reset the load register and the counter read `32'hFFFFFFFF`, the control register reads 0, and both `irq_o` and `sys_rst_o` are low.
- R4: When interrupt-enable (control bit 0) is set, each cycle with `tick_en` high lowers the counter by one. The counter is read at word index 4. The cycle with `tick_en` high in which the counter is 0 is the expiry: it sets `irq_o` and restarts the counter at the load value. With load value L, the interrupt appears after exactly L+1 ticks.
- R5: An expiry that occurs while `irq_o` is still high and reset-enable (control bit 1) is set drives `sys_rst_o` high. This takes L+1 further ticks after the interrupt.
- R6: When reset-enable is clear, later expiries never raise `sys_rst_o`, and `irq_o` stays high.
- R7: An unlocked write of any value to the interrupt-clear register (word index 2) lowers `irq_o` and restarts the counter at the load value. A service of this kind prevents the reset.
- R8: An unlocked write to the load register (word index 0) stores the value and restarts the counter at the new value in the same cycle.
- R9: With interrupt-enable clear, the counter holds its value whatever `tick_en` does. A control write that changes interrupt-enable from clear to set restarts the counter at the load value.
- R10: `irq_o` stays high until it is cleared. `sys_rst_o` stays high, through any register write, until `rst_n` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer enable; the counter steps on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word index |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| irq_o | output | 1 | Level interrupt, first-stage expiry |
| sys_rst_o | output | 1 | Sticky system reset request, second-stage expiry |

## Verification
The bench sweeps small load values with ticks every cycle and with ticks every third cycle. For each case it measures the tick count to the interrupt and to the reset. A design with an off-by-one period, or one that counts clock cycles instead of ticks, shows up as a count other than L+1. Locked writes are checked against the register readback and the outputs, so a lock that guards only some registers is caught. The bench also covers a cleared reset-enable, an interrupt cleared just before the second expiry, and a reset pulse followed by register writes. These catch a design that resets without reset-enable, ignores the service, or lets a write drop the reset request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;
  localparam int unsigned IDX_LOAD  = 0;
  localparam int unsigned IDX_CTRL  = 1;
  localparam int unsigned IDX_ICLR  = 2;
  localparam int unsigned IDX_LOCK  = 3;
  localparam int unsigned IDX_COUNT = 4;

  typedef struct packed {
    logic rst_en;
    logic int_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_q,
  output logic              locked,
  output logic [DATA_W-1:0] load_q,
  output ctrl_t             ctrl_q,
  output logic              load_we,
  output logic              iclr_we,
  output logic              reload_req,
  output logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(IDX_LOAD);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(IDX_CTRL);
  localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(IDX_ICLR);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(IDX_LOCK);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(IDX_COUNT);
  localparam logic [DATA_W-1:0] KEY     = DATA_W'(UNLOCK_KEY);

  logic  lock_we, ctrl_we, int_en_rise;
  ctrl_t ctrl_wr;

  assign ctrl_wr     = ctrl_t'(wdata[1:0]);
  assign lock_we     = wr_en && (addr == A_LOCK);
  assign load_we     = wr_en && !locked && (addr == A_LOAD);
  assign ctrl_we     = wr_en && !locked && (addr == A_CTRL);
  assign iclr_we     = wr_en && !locked && (addr == A_ICLR);
  assign int_en_rise = ctrl_we && ctrl_wr.int_en && !ctrl_q.int_en;
  assign reload_req  = load_we || iclr_we || int_en_rise;
  assign reload_val  = load_we ? wdata : load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      load_q <= '1;
      ctrl_q <= '0;
    end else begin
      if (lock_we) locked <= (wdata != KEY);
      if (load_we) load_q <= wdata;
      if (ctrl_we) ctrl_q <= ctrl_wr;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LOAD:  rdata = load_q;
      A_CTRL:  rdata = {{(DATA_W-2){1'b0}}, ctrl_q.rst_en, ctrl_q.int_en};
      A_LOCK:  rdata = {{(DATA_W-1){1'b0}}, locked};
      A_COUNT: rdata = cnt_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              int_en,
  input  logic              reload_req,
  input  logic [DATA_W-1:0] reload_val,
  input  logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              expire
);
  function automatic logic [DATA_W-1:0] next_count(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] period
  );
    return (cur == '0) ? period : cur - 1'b1;
  endfunction

  logic step;
  assign step   = tick_en && int_en && !reload_req;
  assign expire = step && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '1;
    else if (reload_req) cnt_q <= reload_val;
    else if (step)       cnt_q <= next_count(cnt_q, load_q);
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic iclr_we,
  input  logic rst_en,
  output logic irq_q,
  output logic sys_rst_q
);
  logic second_hit;
  assign second_hit = expire && irq_q && rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      sys_rst_q <= 1'b0;
    end else begin
      if (iclr_we)     irq_q <= 1'b0;
      else if (expire) irq_q <= 1'b1;
      if (second_hit)  sys_rst_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic              locked, load_we, iclr_we, reload_req, expire;
  logic              int_en, rst_en;
  logic [DATA_W-1:0] load_q, reload_val, cnt_q;
  ctrl_t             ctrl_q;

  assign int_en = ctrl_q.int_en;
  assign rst_en = ctrl_q.rst_en;

  wdog_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_q(cnt_q), .locked(locked), .load_q(load_q), .ctrl_q(ctrl_q),
    .load_we(load_we), .iclr_we(iclr_we), .reload_req(reload_req),
    .reload_val(reload_val), .rdata(rdata)
  );

  wdog_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .int_en(int_en),
    .reload_req(reload_req), .reload_val(reload_val), .load_q(load_q),
    .cnt_q(cnt_q), .expire(expire)
  );

  wdog_stage u_stage (
    .clk(clk), .rst_n(rst_n), .expire(expire), .iclr_we(iclr_we),
    .rst_en(rst_en), .irq_q(irq_o), .sys_rst_q(sys_rst_o)
  );
endmodule

// File: rtl/wdog_two_stage_sva.sv
module wdog_two_stage_sva
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              locked,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic              int_en,
  input logic              rst_en,
  input logic              load_we,
  input logic              iclr_we,
  input logic              reload_req,
  input logic              expire,
  input logic              irq_o,
  input logic              sys_rst_o
);
  p_lock_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(IDX_LOCK)) |=> (locked == ($past(wdata) != DATA_W'(UNLOCK_KEY))));

  p_locked_load_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && addr == ADDR_W'(IDX_LOAD)) |=> $stable(load_q));

  p_locked_clear_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && addr == ADDR_W'(IDX_ICLR) && irq_o) |=> irq_o);

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && tick_en && !reload_req && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_first_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !irq_o) |=> (irq_o && cnt_q == $past(load_q)));

  p_second_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && irq_o && rst_en) |=> sys_rst_o);

  p_rst_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> ($past(rst_en) && $past(irq_o)));

  p_clear_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iclr_we |=> (!irq_o && cnt_q == $past(load_q)));

  p_load_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (cnt_q == $past(wdata) && load_q == $past(wdata)));

  p_hold_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !reload_req) |=> $stable(cnt_q));

  p_rst_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> sys_rst_o);

  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !iclr_we) |=> irq_o);
endmodule

bind wdog_two_stage wdog_two_stage_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .locked(locked), .load_q(load_q), .cnt_q(cnt_q),
  .int_en(int_en), .rst_en(rst_en), .load_we(load_we), .iclr_we(iclr_we),
  .reload_req(reload_req), .expire(expire), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/wdog_two_stage_tb_top.sv
`timescale 1ns/1ps
module wdog_two_stage_tb_top;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq_o, sys_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_two_stage #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(idx); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(idx);
    #1 d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  // Counts ticks handed to the block until irq_o (want_rst=0) or sys_rst_o rises.
  task automatic until_event(input bit want_rst, input int div, output int n);
    int phase = 0;
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (want_rst ? sys_rst_o : irq_o) break;
      tick_en = ((phase % div) == 0);
      if (tick_en) n++;
      phase++;
    end
    tick_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    rd(0, v); chk("R3 load reset", v, 32'hFFFFFFFF);
    rd(4, v); chk("R3 count reset", v, 32'hFFFFFFFF);
    rd(1, v); chk("R3 ctrl reset", v, 0);
    chk("R3 irq reset", {31'b0, irq_o}, 0);
    chk("R3 sys_rst reset", {31'b0, sys_rst_o}, 0);

    // R1 lock behaviour
    rd(3, v); chk("R1 unlocked after reset", v, 0);
    wr(3, 32'h1ACCE550); rd(3, v); chk("R1 wrong key locks", v, 1);
    wr(3, KEY); rd(3, v); chk("R1 key unlocks", v, 0);

    // R2 writes ignored while locked
    wr(3, 0);
    wr(0, 32'd7); rd(0, v); chk("R2 locked load", v, 32'hFFFFFFFF);
    rd(4, v); chk("R2 locked load no reload", v, 32'hFFFFFFFF);
    wr(1, 32'd3); rd(1, v); chk("R2 locked ctrl", v, 0);
    wr(3, KEY);

    // R4/R5 sweep: load values and tick rates
    for (int div = 1; div <= 3; div += 2) begin
      for (int l = 0; l < 6; l++) begin
        wr(3, KEY); wr(0, l); wr(2, 0); wr(1, 3);
        until_event(1'b0, div, n);
        chk($sformatf("R4 ticks to irq L=%0d div=%0d", l, div), n, l + 1);
        rd(4, v); chk("R4 reload after expiry", v, l);
        chk("R4 no early reset", {31'b0, sys_rst_o}, 0);
        until_event(1'b1, div, n);
        chk($sformatf("R5 ticks to reset L=%0d div=%0d", l, div), n, l + 1);
        // R10 sticky reset through writes
        wr(2, 0); wr(1, 0);
        chk("R10 reset survives writes", {31'b0, sys_rst_o}, 1);
        do_reset();
        chk("R10 reset cleared by rst_n", {31'b0, sys_rst_o}, 0);
      end
    end

    // R6 no reset when reset-enable clear
    wr(0, 2); wr(1, 1);
    until_event(1'b0, 1, n); chk("R6 irq ticks", n, 3);
    ticks(30);
    chk("R6 no reset", {31'b0, sys_rst_o}, 0);
    chk("R10 irq level held", {31'b0, irq_o}, 1);

    // R2 locked clear ignored
    wr(3, 32'h0); wr(2, 0);
    chk("R2 locked clear ignored", {31'b0, irq_o}, 1);
    wr(3, KEY);

    // R7 clear reloads and kick avoids reset
    wr(1, 3); wr(0, 3); ticks(2);
    wr(2, 0);
    chk("R7 clear drops irq", {31'b0, irq_o}, 0);
    rd(4, v); chk("R7 clear reloads", v, 3);
    for (int k = 0; k < 3; k++) begin
      until_event(1'b0, 1, n); chk("R7 period after kick", n, 4);
      wr(2, 0);
    end
    chk("R7 kick prevents reset", {31'b0, sys_rst_o}, 0);

    // R8 load write reloads immediately
    wr(0, 32'd9); rd(4, v); chk("R8 count takes new load", v, 9);
    rd(0, v); chk("R8 load stored", v, 9);

    // R9 hold when disabled, reload on enable rise
    wr(1, 1); wr(0, 10); ticks(4);
    rd(4, v); chk("R4 decrement per tick", v, 6);
    wr(1, 0); ticks(5);
    rd(4, v); chk("R9 hold when disabled", v, 6);
    wr(1, 1); rd(4, v); chk("R9 reload on enable", v, 10);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule